// File: doc/BRIEF.md
# Scan Chain Port Router

This block turns parallel 32-bit words written over a simple register port into a serial bit stream and sends it to one of eight selectable chain ports. A divided shift clock goes out with the data. Ports 0 to 3 feed I/O configuration shift registers. On those ports the block is a bare parallel-to-serial converter: it drives only a clock line and a data line, and it has no mode line and no TAP state walking. Port 7 reaches an external JTAG TAP controller with the full clock, mode, data-in and data-out set. The returned data-out bits are collected into a readback word. Ports 4, 5 and 6 are not wired.

The TAP port is used only while an enable bit in a control register is set. Reset clears that bit. While it is clear, the TAP pins are handed through to the external JTAG pins. An external configure-I/O override, reported by the TAP, takes over all four I/O chain ports. While the override is active, shift requests aimed at those ports are refused. While a shift runs, a busy flag blocks changes to the data, select, mode and enable registers. Any write that tries such a change sets a sticky error flag.

Register map, with `wr_addr` selecting the register:

| Address | Register | Fields |
|---|---|---|
| 0 | shift data | `wr_data[31:0]` is the word to send; the write also starts the shift |
| 1 | port select | `wr_data[2:0]` is the port number, 0 to 7 |
| 2 | length | `wr_data[5:0]` is the bit count |
| 3 | divider | `wr_data[7:0]` is the half period in system clocks |
| 4 | mode word | `wr_data[31:0]` is the TMS word for port 7 |
| 5 | control | `wr_data[0]` is the TAP enable |

Top module: `scan_port_router`

## Requirements
- R1: The port select register at address 1 takes `wr_data[2:0]`. A data write (address 0) made while port 4, 5 or 6 is selected is ignored: `busy` stays 0 and no chain or TAP output toggles.
- R2: A shift on port p in 0..3 toggles only `io_tck[p]` and `io_tdi[p]`. All other `io_tck`/`io_tdi` bits and all TAP outputs stay at 0.
- R3: Data goes out LSB first, one bit per shift clock period. The number of bits is the length register at address 2, `wr_data[5:0]`. A value of 0, or any value above 32, means 32.
- R4: The shift clock idles low and starts each bit low. Each half period lasts D system clocks, where D is the divider register at address 3, `wr_data[7:0]`, and 0 means 1. `busy` stays high for exactly length*2*D cycles. Data changes only on falling shift clock edges.
- R5: Port 7 is driven only while the control register bit 0 (address 5) is set. While it is clear, `tap_tck`/`tap_tms`/`tap_tdi` follow `ext_tck`/`ext_tms`/`ext_tdi`, `ext_tdo` follows `tap_tdo`, and a data write with port 7 selected is ignored. While it is set, `ext_tdo` is 0.
- R6: Reset clears the TAP enable, which hands the TAP back to the external pins.
- R7: On port 7 the mode word at address 4 goes out on `tap_tms`, LSB first, in step with the data bits.
- R8: On port 7, `tap_tdo` is sampled on each rising shift clock edge. Bit i is stored in `rdback[i]`, and the bits above the length read 0.
- R9: While `cfg_ovr` is 1, `io_tck` is driven by `ovr_tck` on all four ports and `io_tdi` equals `ovr_tdi`. A data write with port 0..3 selected is then ignored and does not set `err`.
- R10: While `busy` is 1, writes to addresses 0, 1, 4 and 5 are ignored and set `err`. `err` stays set until reset.
- R11: `io_hbank` marks port 3 as the horizontal bank and ports 0 to 2 as vertical: it reads 4'b1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| busy | output | 1 | A shift is in progress |
| err | output | 1 | Sticky flag for a write refused while busy |
| rdback | output | 32 | Data-out bits captured from the TAP |
| io_tck | output | 4 | Shift clock for each I/O chain port |
| io_tdi | output | 4 | Serial data for each I/O chain port |
| io_hbank | output | 4 | Per-port bank type, 1 = horizontal |
| cfg_ovr | input | 1 | External configure-I/O override active |
| ovr_tck | input | 1 | Override shift clock |
| ovr_tdi | input | 4 | Override serial data, one bit per port |
| tap_tck | output | 1 | Test clock to the TAP controller |
| tap_tms | output | 1 | Test mode select to the TAP controller |
| tap_tdi | output | 1 | Test data to the TAP controller |
| tap_tdo | input | 1 | Test data from the TAP controller |
| ext_tck | input | 1 | External JTAG clock pin |
| ext_tms | input | 1 | External JTAG mode pin |
| ext_tdi | input | 1 | External JTAG data-in pin |
| ext_tdo | output | 1 | External JTAG data-out pin |

## Verification
Random words are shifted on each wired port with random lengths (1 to 32) and dividers (1 to 4). The bench rebuilds the serial stream at the rising shift clock edges, so bit order, truncation to the length and the port chosen are all tested, and the length of the busy window separates divider errors from length errors. On port 7 a random data-out pattern is fed back, which tests both the capture alignment and the clearing of the bits above the length. Directed cases cover the following:
- the unwired ports;
- a disabled TAP port, and enable loss at reset;
- the override;
- refused writes in the middle of a shift;
- length 0 and divider 0.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_SEL  = 3'd1,
    REG_LEN  = 3'd2,
    REG_DIV  = 3'd3,
    REG_TMS  = 3'd4,
    REG_CTRL = 3'd5
  } scan_reg_e;
endpackage

// File: rtl/scan_clkgen.sv
module scan_clkgen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            sck,
  output logic            rise,
  output logic            fall
);
  logic [DIVW-1:0] cnt_q, cnt_d, div_q, div_d;
  logic            sck_q, sck_d;
  logic            wrap;

  assign wrap = run && (cnt_q == div_q - DIVW'(1));
  assign rise = wrap && !sck_q;
  assign fall = wrap && sck_q;
  assign sck  = sck_q;

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    div_d = div_q;
    if (start) begin
      cnt_d = '0;
      sck_d = 1'b0;
      div_d = div;
    end else if (run) begin
      if (wrap) begin
        cnt_d = '0;
        sck_d = !sck_q;
      end else begin
        cnt_d = cnt_q + DIVW'(1);
      end
    end else begin
      cnt_d = '0;
      sck_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
      div_q <= DIVW'(1);
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
      div_q <= div_d;
    end
  end

  // R4: the shift clock rests low whenever no shift runs
  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sck_q);
endmodule

// File: rtl/scan_shifter.sv
module scan_shifter #(
  parameter int W    = 32,
  parameter int LENW = 6,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [W-1:0]    data_in,
  input  logic [W-1:0]    tms_in,
  input  logic [LENW-1:0] len_in,
  input  logic [DIVW-1:0] div_in,
  input  logic            tdo,
  output logic            busy,
  output logic            sck,
  output logic            sd,
  output logic            sms,
  output logic [W-1:0]    rdback
);
  localparam int IDXW = $clog2(W);

  logic [W-1:0]    sh_q, sh_d, tm_q, tm_d, rd_q, rd_d;
  logic [LENW-1:0] left_q, left_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            busy_q, busy_d;
  logic            rise, fall;

  scan_clkgen #(.DIVW(DIVW)) u_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .run   (busy_q),
    .div   (div_in),
    .sck   (sck),
    .rise  (rise),
    .fall  (fall)
  );

  always_comb begin
    sh_d   = sh_q;
    tm_d   = tm_q;
    rd_d   = rd_q;
    left_d = left_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    if (start) begin
      sh_d   = data_in;
      tm_d   = tms_in;
      rd_d   = '0;
      left_d = len_in;
      idx_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (rise) rd_d[idx_q] = tdo;
      if (fall) begin
        if (left_q == LENW'(1)) begin
          busy_d = 1'b0;
        end else begin
          sh_d   = sh_q >> 1;
          tm_d   = tm_q >> 1;
          left_d = left_q - LENW'(1);
          idx_d  = idx_q + IDXW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      tm_q   <= '0;
      rd_q   <= '0;
      left_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      tm_q   <= tm_d;
      rd_q   <= rd_d;
      left_q <= left_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  assign busy   = busy_q;
  assign sd     = sh_q[0];
  assign sms    = tm_q[0];
  assign rdback = rd_q;

  // R4: serial data holds while the shift clock is high
  a_r4_data_holds_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && sck && $past(sck)) |-> $stable(sh_q[0]));
  // R3: a running shift always has bits left to send
  a_r3_bits_left: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != '0));
endmodule

// File: rtl/scan_portmux.sv
module scan_portmux #(
  parameter int NIO      = 4,
  parameter int SELW     = 3,
  parameter int TAP_PORT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic [SELW-1:0] sel,
  input  logic            sck,
  input  logic            sd,
  input  logic            sms,
  input  logic            tap_en,
  input  logic            ovr,
  input  logic            ovr_tck,
  input  logic [NIO-1:0]  ovr_tdi,
  input  logic            ext_tck,
  input  logic            ext_tms,
  input  logic            ext_tdi,
  input  logic            tap_tdo,
  output logic [NIO-1:0]  io_tck,
  output logic [NIO-1:0]  io_tdi,
  output logic            tap_tck,
  output logic            tap_tms,
  output logic            tap_tdi,
  output logic            ext_tdo
);
  logic tap_act;

  for (genvar g = 0; g < NIO; g++) begin : g_io
    logic act;
    assign act       = busy && (sel == SELW'(g));
    assign io_tck[g] = ovr ? ovr_tck    : (act && sck);
    assign io_tdi[g] = ovr ? ovr_tdi[g] : (act && sd);
  end

  assign tap_act = busy && (sel == SELW'(TAP_PORT));

  always_comb begin
    if (tap_en) begin
      tap_tck = tap_act && sck;
      tap_tms = tap_act && sms;
      tap_tdi = tap_act && sd;
      ext_tdo = 1'b0;
    end else begin
      tap_tck = ext_tck;
      tap_tms = ext_tms;
      tap_tdi = ext_tdi;
      ext_tdo = tap_tdo;
    end
  end

  // R2: without the override, at most one chain port carries a clock
  a_r2_one_chain_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr |-> $onehot0(io_tck));
  // R5: an enabled TAP port stays quiet between shifts
  a_r5_tap_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_en && !busy) |-> !tap_tck);
endmodule

// File: rtl/scan_port_router.sv
module scan_port_router #(
  parameter int              W        = 32,
  parameter int              NPORT    = 8,
  parameter int              NIO      = 4,
  parameter int              TAP_PORT = 7,
  parameter int              DIVW     = 8,
  parameter logic [NIO-1:0]  HBANK    = 4'b1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  output logic            busy,
  output logic            err,
  output logic [W-1:0]    rdback,
  output logic [NIO-1:0]  io_tck,
  output logic [NIO-1:0]  io_tdi,
  output logic [NIO-1:0]  io_hbank,
  input  logic            cfg_ovr,
  input  logic            ovr_tck,
  input  logic [NIO-1:0]  ovr_tdi,
  output logic            tap_tck,
  output logic            tap_tms,
  output logic            tap_tdi,
  input  logic            tap_tdo,
  input  logic            ext_tck,
  input  logic            ext_tms,
  input  logic            ext_tdi,
  output logic            ext_tdo
);
  import scan_pkg::*;

  localparam int SELW = $clog2(NPORT);
  localparam int LENW = $clog2(W) + 1;

  logic            rs_q1, rs_q2, rst_ni;
  logic [SELW-1:0] sel_q, sel_d;
  logic [LENW-1:0] len_q, len_d, len_eff;
  logic [DIVW-1:0] div_q, div_d, div_eff;
  logic [W-1:0]    tms_q, tms_d;
  logic            en_q, en_d, err_q, err_d;
  logic            port_ok, start, locked_wr;
  logic            sck, sd, sms;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_ni = rs_q2;

  assign len_eff = ((len_q == '0) || (len_q > LENW'(W))) ? LENW'(W) : len_q;
  assign div_eff = (div_q == '0) ? DIVW'(1) : div_q;

  assign port_ok = ((sel_q < SELW'(NIO)) && !cfg_ovr) ||
                   ((sel_q == SELW'(TAP_PORT)) && en_q);
  assign locked_wr = (wr_addr == REG_DATA) || (wr_addr == REG_SEL) ||
                     (wr_addr == REG_TMS)  || (wr_addr == REG_CTRL);
  assign start = wr_en && !busy && (wr_addr == REG_DATA) && port_ok;

  always_comb begin
    sel_d = sel_q;
    len_d = len_q;
    div_d = div_q;
    tms_d = tms_q;
    en_d  = en_q;
    err_d = err_q;
    if (wr_en) begin
      if (busy) begin
        if (locked_wr) err_d = 1'b1;
      end else begin
        case (wr_addr)
          REG_SEL:  sel_d = wr_data[SELW-1:0];
          REG_TMS:  tms_d = wr_data;
          REG_CTRL: en_d  = wr_data[0];
          default: ;
        endcase
      end
      if (wr_addr == REG_LEN) len_d = wr_data[LENW-1:0];
      if (wr_addr == REG_DIV) div_d = wr_data[DIVW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      len_q <= '0;
      div_q <= DIVW'(1);
      tms_q <= '0;
      en_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      len_q <= len_d;
      div_q <= div_d;
      tms_q <= tms_d;
      en_q  <= en_d;
      err_q <= err_d;
    end
  end

  scan_shifter #(.W(W), .LENW(LENW), .DIVW(DIVW)) u_shifter (
    .clk     (clk),
    .rst_n   (rst_ni),
    .start   (start),
    .data_in (wr_data),
    .tms_in  (tms_q),
    .len_in  (len_eff),
    .div_in  (div_eff),
    .tdo     (tap_tdo),
    .busy    (busy),
    .sck     (sck),
    .sd      (sd),
    .sms     (sms),
    .rdback  (rdback)
  );

  scan_portmux #(.NIO(NIO), .SELW(SELW), .TAP_PORT(TAP_PORT)) u_portmux (
    .clk     (clk),
    .rst_n   (rst_ni),
    .busy    (busy),
    .sel     (sel_q),
    .sck     (sck),
    .sd      (sd),
    .sms     (sms),
    .tap_en  (en_q),
    .ovr     (cfg_ovr),
    .ovr_tck (ovr_tck),
    .ovr_tdi (ovr_tdi),
    .ext_tck (ext_tck),
    .ext_tms (ext_tms),
    .ext_tdi (ext_tdi),
    .tap_tdo (tap_tdo),
    .io_tck  (io_tck),
    .io_tdi  (io_tdi),
    .tap_tck (tap_tck),
    .tap_tms (tap_tms),
    .tap_tdi (tap_tdi),
    .ext_tdo (ext_tdo)
  );

  assign err      = err_q;
  assign io_hbank = HBANK;

  // R1: a data write toward an unwired port never starts a shift
  a_r1_unwired_no_start: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !busy && (wr_addr == REG_DATA) && (sel_q > SELW'(NIO-1)) &&
     (sel_q != SELW'(TAP_PORT))) |=> !busy);
  // R10: the error flag is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(err_q) |-> err_q);
  // R10: the port select cannot move during a shift
  a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(busy) |-> $stable(sel_q));
endmodule

// File: tb/scan_port_router_bench.sv
module scan_port_router_bench;
  localparam int CLK_P = 10;

  logic        clk, rst_n, wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data, rdback;
  logic        busy, err;
  logic [3:0]  io_tck, io_tdi, io_hbank, ovr_tdi;
  logic        cfg_ovr, ovr_tck, tap_tck, tap_tms, tap_tdi, tap_tdo;
  logic        ext_tck, ext_tms, ext_tdi, ext_tdo;

  int n_chk, n_bad;
  logic [31:0] got_d, got_m;
  int          got_n, got_cyc, quiet_bad;

  scan_port_router u_scan_port_router (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .err(err), .rdback(rdback), .io_tck(io_tck), .io_tdi(io_tdi),
    .io_hbank(io_hbank), .cfg_ovr(cfg_ovr), .ovr_tck(ovr_tck), .ovr_tdi(ovr_tdi),
    .tap_tck(tap_tck), .tap_tms(tap_tms), .tap_tdi(tap_tdi), .tap_tdo(tap_tdo),
    .ext_tck(ext_tck), .ext_tms(ext_tms), .ext_tdi(ext_tdi), .ext_tdo(ext_tdo)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(input int len);
    return (len >= 32) ? 32'hffff_ffff : ((32'd1 << len) - 32'd1);
  endfunction

  function automatic int eff_len(input int l);
    return (l == 0 || l > 32) ? 32 : l;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Follows a running shift at the falling system clock edges and rebuilds
  // the stream from the rising edges of the shift clock on the chosen port.
  task automatic watch(input int port, input int pre, input logic [31:0] tdo_pat);
    logic prev;
    logic tck_now;
    prev = 1'b0; got_d = '0; got_m = '0; got_n = 0; got_cyc = pre; quiet_bad = 0;
    tap_tdo = tdo_pat[0];
    while (busy) begin
      got_cyc++;
      tck_now = (port == 7) ? tap_tck : io_tck[port];
      if (tck_now && !prev && got_n < 32) begin
        got_d[got_n] = (port == 7) ? tap_tdi : io_tdi[port];
        got_m[got_n] = tap_tms;
        got_n++;
      end
      prev = tck_now;
      if (got_n < 32) tap_tdo = tdo_pat[got_n];
      if (port == 7) begin
        if (io_tck != 4'b0 || io_tdi != 4'b0) quiet_bad++;
      end else begin
        if ((io_tck & ~(4'b1 << port)) != 4'b0 || tap_tck || tap_tms) quiet_bad++;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_shift(input int port, input logic [31:0] word, input logic [31:0] tms,
                           input int len, input int dv, input logic [31:0] pat);
    int el, ed;
    el = eff_len(len);
    ed = (dv == 0) ? 1 : dv;
    wr(3'd1, 32'(port));
    wr(3'd2, 32'(len));
    wr(3'd3, 32'(dv));
    if (port == 7) wr(3'd4, tms);
    wr(3'd0, word);
    check("R3 busy after start", {31'b0, busy}, 32'd1);
    watch(port, 0, pat);
    check("R3 bit count", 32'(got_n), 32'(el));
    check("R3 serial data LSB first", got_d, word & lmask(el));
    check("R4 busy cycles", 32'(got_cyc), 32'(el * 2 * ed));
    check("R2 other ports quiet", 32'(quiet_bad), 32'd0);
    if (port == 7) begin
      check("R7 mode bits", got_m & lmask(el), tms & lmask(el));
      check("R8 readback", rdback, pat & lmask(el));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int ports [5];
    n_chk = 0; n_bad = 0;
    ports = '{0, 1, 2, 3, 7};
    wr_en = 0; wr_addr = 0; wr_data = 0; cfg_ovr = 0; ovr_tck = 0; ovr_tdi = 0;
    tap_tdo = 0; ext_tck = 0; ext_tms = 0; ext_tdi = 0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // reset state
    check("R10 err after reset", {31'b0, err}, 32'd0);
    check("R4 busy after reset", {31'b0, busy}, 32'd0);
    check("R2 io idle after reset", {28'b0, io_tck}, 32'd0);
    check("R11 bank types", {28'b0, io_hbank}, 32'h8);
    ext_tck = 1; ext_tms = 0; ext_tdi = 1; tap_tdo = 1;
    #1;
    check("R6 tap handed to pins", {29'b0, tap_tck, tap_tms, tap_tdi}, 32'b101);
    check("R5 ext_tdo passthrough", {31'b0, ext_tdo}, 32'd1);

    // R5: port 7 while disabled is refused
    wr(3'd1, 32'd7);
    wr(3'd0, 32'hdead_beef);
    check("R5 disabled tap refuses shift", {31'b0, busy}, 32'd0);
    ext_tck = 0; ext_tdi = 0; tap_tdo = 0;

    // R1: unwired ports
    for (int p = 4; p < 7; p++) begin
      wr(3'd1, 32'(p));
      wr(3'd0, 32'hffff_ffff);
      check("R1 unwired port no busy", {31'b0, busy}, 32'd0);
      repeat (4) @(negedge clk);
      check("R1 unwired port no activity",
            {26'b0, io_tck, tap_tck, tap_tdi}, 32'd0);
    end

    // enable the TAP port
    wr(3'd5, 32'd1);
    ext_tck = 1;
    #1;
    check("R5 enabled tap ignores pins", {31'b0, tap_tck}, 32'd0);
    check("R5 ext_tdo low when enabled", {31'b0, ext_tdo}, 32'd0);
    ext_tck = 0;

    // directed corners: full length via 0, divider 0
    run_shift(2, 32'h8000_0001, 32'h0, 0, 0, 32'h0);
    run_shift(7, 32'ha5c3_0f96, 32'h1234_5678, 1, 3, 32'hffff_ffff);
    run_shift(0, 32'h0000_00ff, 32'h0, 40, 1, 32'h0);

    // random mix
    for (int i = 0; i < 24; i++) begin
      run_shift(ports[$urandom_range(0, 4)], $urandom, $urandom,
                $urandom_range(1, 32), $urandom_range(1, 4), $urandom);
    end

    // R10: refused writes during a shift
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd8);
    wr(3'd3, 32'd4);
    wr(3'd0, 32'h0000_005a);
    wr(3'd1, 32'd2);
    wr(3'd0, 32'h0000_00ff);
    watch(0, 2, 32'h0);
    check("R10 err set by busy write", {31'b0, err}, 32'd1);
    check("R10 shift unchanged by busy writes", got_d, 32'h0000_005a);
    check("R10 cycles unchanged", 32'(got_cyc), 32'd64);
    wr(3'd0, 32'h0000_0033);
    watch(0, 0, 32'h0);
    check("R10 select kept after busy write", got_d, 32'h0000_0033);
    check("R10 err sticky", {31'b0, err}, 32'd1);

    // R9: override
    cfg_ovr = 1; ovr_tck = 1; ovr_tdi = 4'b0101;
    #1;
    check("R9 override clocks", {28'b0, io_tck}, 32'hf);
    check("R9 override data", {28'b0, io_tdi}, 32'h5);
    do_reset();
    wr(3'd1, 32'd2);
    wr(3'd0, 32'h1111_1111);
    check("R9 blocked shift", {31'b0, busy}, 32'd0);
    check("R9 no error on blocked shift", {31'b0, err}, 32'd0);
    cfg_ovr = 0; ovr_tck = 0; ovr_tdi = 0;
    #1;
    check("R9 release override", {28'b0, io_tck}, 32'h0);

    // R6: reset drops the TAP enable
    wr(3'd5, 32'd1);
    do_reset();
    ext_tck = 1; ext_tms = 1;
    #1;
    check("R6 enable cleared by reset", {30'b0, tap_tck, tap_tms}, 32'b11);
    ext_tck = 0; ext_tms = 0;
    wr(3'd1, 32'd7);
    wr(3'd0, 32'h1);
    check("R6 tap refused after reset", {31'b0, busy}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule